// File: doc/BRIEF.md
# Programmable Stride Prefetch Engine

This block sits beside an on-chip cache and issues data prefetches that software has arranged in advance. Software loads each of four table slots through a fill port. A fill supplies a trigger instruction address, a starting prefetch address, a signed stride, a firing interval and a warm-up threshold. In every cycle with a valid program counter, each valid slot compares that counter against its trigger address. A slot fires when it has seen its trigger a set number of times and has already passed its warm-up. The slot's current address becomes a request, and the slot then steps that address by the stride.

Requests wait in a four-deep outstanding-request queue. A small issue state machine drains the queue one request at a time over a valid/ready handshake. The machine has three states. **IDLE** waits for the queue to hold something. **ISSUE** drives the head request until it is accepted. **WAIT_RSP** waits for the memory response, then removes the head and returns to IDLE. The three transitions are: queue non-empty (IDLE to ISSUE), request accepted (ISSUE to WAIT_RSP), and response received (WAIT_RSP to IDLE). A request that finds the queue full is dropped and counted. The memory side used in the bench answers five cycles after acceptance.

Top module: `pfe_top`

## Requirements
- R1: A fill with `fill_en` high writes all five fields of slot `fill_idx` at once and marks it valid. A slot that has never been filled since reset never produces a request, whatever the PC.
- R2: A slot counts a trigger match only in a cycle where `pc_valid` is high and `pc` equals its trigger address. Other PC values and cycles with `pc_valid` low have no effect on it.
- R3: A slot's firing condition is met once every `count` matches of its trigger. A count of 0 behaves as 1, so the condition is met on every match.
- R4: The first `start` times a slot's firing condition is met produce no request. Every later time it is met produces exactly one request.
- R5: A slot's first request carries its programmed base address. Each later request from that slot carries the previous address plus the stride, taken modulo 2^AW, so a negative stride gives descending addresses.
- R6: A fill clears the slot's match counter, its warm-up counter and any request it has waiting, so counting restarts from zero.
- R7: When several slots fire in the same cycle, their requests reach memory in ascending slot-index order.
- R8: The queue holds at most 4 requests. The head counts until its response returns. A request that finds the queue full is discarded, and `drop_count` increases by one for each discarded request. `drop_count` is 0 after reset.
- R9: At most one request is outstanding. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`. After acceptance, no new request is presented until `mem_rsp_valid` has returned. After reset `mem_req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Fill command strobe |
| fill_idx | input | 2 | Slot written by the fill |
| fill_trig | input | 32 | Trigger instruction address |
| fill_base | input | 32 | First prefetch address |
| fill_stride | input | 32 | Signed address step |
| fill_count | input | 8 | Matches per firing condition (0 acts as 1) |
| fill_start | input | 8 | Conditions skipped before prefetching |
| pc_valid | input | 1 | Program counter valid this cycle |
| pc | input | 32 | Program counter |
| mem_req_valid | output | 1 | Prefetch request presented |
| mem_req_addr | output | 32 | Prefetch request address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| drop_count | output | 8 | Number of discarded requests |

## Verification
A wrong match or warm-up counter shows up as a missing, extra or mis-addressed request. The scoreboard catches it when that request is accepted, a few cycles after the trigger PC. A corrupted slot address shows as a wrong value on `mem_req_addr` at the next firing. A queue pointer or occupancy error shows either as requests reordered against the expected stream or as a wrong `drop_count` once the queue is held full. An issue state machine that leaves WAIT_RSP early shows as a second `mem_req_valid` inside the five-cycle response window.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RSP
    } issue_st_e;
endpackage

// File: rtl/pfe_entry.sv
module pfe_entry #(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_hit,
    input  logic [AW-1:0] fill_trig,
    input  logic [AW-1:0] fill_base,
    input  logic [AW-1:0] fill_stride,
    input  logic [CW-1:0] fill_count,
    input  logic [CW-1:0] fill_start,
    input  logic          pc_valid,
    input  logic [AW-1:0] pc,
    input  logic          grant,
    output logic          pend,
    output logic [AW-1:0] pend_addr,
    output logic          lost
);
    logic          vld;
    logic [AW-1:0] trig, cur, step;
    logic [CW-1:0] cnt, strt, mcnt, scnt;
    logic [CW:0]   next_m, ceff;
    logic          hit, sat, fire;

    always_comb begin
        hit    = vld && pc_valid && (pc == trig);
        next_m = {1'b0, mcnt} + 1'b1;
        ceff   = (cnt == '0) ? (CW+1)'(1) : {1'b0, cnt};
        sat    = hit && (next_m >= ceff);
        fire   = sat && (scnt >= strt);
        lost   = fire && pend && !grant && !fill_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0; trig <= '0; cur <= '0; step <= '0;
            cnt <= '0; strt <= '0; mcnt <= '0; scnt <= '0;
            pend <= 1'b0; pend_addr <= '0;
        end else if (fill_hit) begin
            vld  <= 1'b1;
            trig <= fill_trig;
            cur  <= fill_base;
            step <= fill_stride;
            cnt  <= fill_count;
            strt <= fill_start;
            mcnt <= '0;
            scnt <= '0;
            pend <= 1'b0;
        end else begin
            if (hit)
                mcnt <= sat ? '0 : next_m[CW-1:0];
            if (sat && !fire)
                scnt <= scnt + 1'b1;
            if (fire) begin
                pend_addr <= cur;
                cur       <= cur + step;
                pend      <= 1'b1;
            end else if (grant) begin
                pend <= 1'b0;
            end
        end
    end

    p_fill_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_hit |=> (!pend && mcnt == '0 && scnt == '0));
    p_pend_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(pc_valid));
endmodule

// File: rtl/pfe_queue.sv
module pfe_queue #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic [AW-1:0] enq_addr,
    output logic          full,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid
);
    import pfe_pkg::*;
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] occ;
    logic          pop;
    issue_st_e     st, st_nx;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full = (occ == CW'(DEPTH));
        pop  = (st == ST_WAIT_RSP) && mem_rsp_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0; rptr <= '0; occ <= '0;
        end else begin
            if (enq) begin
                slots[wptr] <= enq_addr;
                wptr        <= bump(wptr);
            end
            if (pop)
                rptr <= bump(rptr);
            occ <= occ + CW'(enq) - CW'(pop);
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (occ != '0)    st_nx = ST_ISSUE;
            ST_ISSUE:    if (mem_req_ready) st_nx = ST_WAIT_RSP;
            ST_WAIT_RSP: if (mem_rsp_valid) st_nx = ST_IDLE;
            default:                        st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        mem_req_valid = (st == ST_ISSUE);
        mem_req_addr  = slots[rptr];
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (occ != '0));
endmodule

// File: rtl/pfe_top.sv
module pfe_top #(
    parameter int AW    = 32,
    parameter int CW    = 8,
    parameter int NENT  = 4,
    parameter int QDEP  = 4,
    parameter int DW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_en,
    input  logic [$clog2(NENT)-1:0] fill_idx,
    input  logic [AW-1:0]           fill_trig,
    input  logic [AW-1:0]           fill_base,
    input  logic [AW-1:0]           fill_stride,
    input  logic [CW-1:0]           fill_count,
    input  logic [CW-1:0]           fill_start,
    input  logic                    pc_valid,
    input  logic [AW-1:0]           pc,
    output logic                    mem_req_valid,
    output logic [AW-1:0]           mem_req_addr,
    input  logic                    mem_req_ready,
    input  logic                    mem_rsp_valid,
    output logic [DW-1:0]           drop_count
);
    localparam int IW = $clog2(NENT);

    logic [NENT-1:0] pend, grant, lost;
    logic [AW-1:0]   pend_addr [NENT];
    logic [AW-1:0]   sel_addr;
    logic            any_pend, full, enq;
    logic [DW-1:0]   drop_inc;

    for (genvar gi = 0; gi < NENT; gi++) begin : g_slot
        pfe_entry #(.AW(AW), .CW(CW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .fill_hit(fill_en && (fill_idx == IW'(gi))),
            .fill_trig(fill_trig), .fill_base(fill_base), .fill_stride(fill_stride),
            .fill_count(fill_count), .fill_start(fill_start),
            .pc_valid(pc_valid), .pc(pc),
            .grant(grant[gi]),
            .pend(pend[gi]), .pend_addr(pend_addr[gi]), .lost(lost[gi])
        );
    end

    always_comb begin
        grant    = '0;
        sel_addr = '0;
        any_pend = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            if (pend[i] && !any_pend) begin
                grant[i] = 1'b1;
                sel_addr = pend_addr[i];
                any_pend = 1'b1;
            end
        end
        enq      = any_pend && !full;
        drop_inc = DW'(any_pend && full);
        for (int i = 0; i < NENT; i++)
            drop_inc = drop_inc + DW'(lost[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drop_count <= '0;
        else        drop_count <= drop_count + drop_inc;
    end

    pfe_queue #(.AW(AW), .DEPTH(QDEP)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .enq(enq), .enq_addr(sel_addr), .full(full),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid)
    );

    p_grant_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & pend) == grant));
    p_no_silent_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(any_pend && full) && lost == '0) |=> (drop_count == $past(drop_count)));
endmodule

// File: tb/pfe_top_bench.sv
`timescale 1ns/1ps
module pfe_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_idx = '0;
    logic [31:0] fill_trig = '0, fill_base = '0, fill_stride = '0;
    logic [7:0]  fill_count = '0, fill_start = '0;
    logic        pc_valid = 1'b0;
    logic [31:0] pc = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  drop_count;

    int checks = 0, errors = 0;
    logic [31:0] sb[$];
    bit          outstanding = 1'b0;
    bit          blocked = 1'b0;
    int          held = 0, exp_drops = 0;

    logic [31:0] m_trig[4], m_cur[4], m_step[4];
    int          m_cnt[4], m_start[4], m_mc[4], m_sc[4];
    bit          m_vld[4];

    always #2.5 clk = ~clk;

    pfe_top u_pfe_top (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_trig(fill_trig), .fill_base(fill_base), .fill_stride(fill_stride),
        .fill_count(fill_count), .fill_start(fill_start),
        .pc_valid(pc_valid), .pc(pc),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic fill(input int idx, input logic [31:0] trig, base, stride, input int cnt, st);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 2'(idx); fill_trig = trig; fill_base = base;
        fill_stride = stride; fill_count = 8'(cnt); fill_start = 8'(st);
        m_vld[idx] = 1'b1; m_trig[idx] = trig; m_cur[idx] = base; m_step[idx] = stride;
        m_cnt[idx] = cnt; m_start[idx] = st; m_mc[idx] = 0; m_sc[idx] = 0;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // driver: computes expected requests from R1..R5, R7, R8 and presents one PC
    task automatic hit(input logic [31:0] addr);
        for (int i = 0; i < 4; i++) begin
            if (m_vld[i] && m_trig[i] == addr) begin
                m_mc[i]++;
                if (m_mc[i] >= ((m_cnt[i] == 0) ? 1 : m_cnt[i])) begin
                    m_mc[i] = 0;
                    if (m_sc[i] < m_start[i]) m_sc[i]++;
                    else begin
                        if (blocked && held >= 4) exp_drops++;
                        else begin sb.push_back(m_cur[i]); held++; end
                        m_cur[i] = m_cur[i] + m_step[i];
                    end
                end
            end
        end
        @(negedge clk);
        pc_valid = 1'b1; pc = addr;
        @(negedge clk);
        pc_valid = 1'b0; pc = 32'hdead_beef;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((sb.size() != 0 || outstanding) && t < 3000) begin
            @(negedge clk); t++;
        end
        repeat (12) @(negedge clk);
        check(sb.size() == 0 && !mem_req_valid, req, 32'(sb.size()), 32'd0);
        held = 0;
    endtask

    // monitor + memory model with 5-cycle response
    always begin
        @(negedge clk);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1/R2 unexpected request", mem_req_addr, 32'hffff_ffff);
            end else begin
                check(mem_req_addr == sb[0], "R5/R7 request address", mem_req_addr, sb[0]);
                void'(sb.pop_front());
            end
            @(posedge clk);
            outstanding = 1'b1;
            repeat (4) @(posedge clk);
            #1 mem_rsp_valid = 1'b1;
            @(posedge clk);
            #1 mem_rsp_valid = 1'b0;
            outstanding = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && outstanding && mem_req_valid)
            check(1'b0, "R9 request while outstanding", 32'd1, 32'd0);
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req_valid, "R9 reset valid low", 32'(mem_req_valid), 32'd0);
        check(drop_count == 0, "R8 reset drop count", 32'(drop_count), 32'd0);

        // R1: unfilled slots (reset trigger 0) stay silent
        hit(32'h0); hit(32'h0); hit(32'h0);
        drain("R1 unfilled silent");

        // R3/R5: count 1, start 0, ascending stride
        fill(0, 32'h100, 32'h1000, 32'h40, 1, 0);
        hit(32'h100); hit(32'h100); hit(32'h100);
        drain("R3 every match");

        // R2/R3/R4: count 3, start 2, with unrelated PCs between
        fill(1, 32'h200, 32'h8000, 32'h100, 3, 2);
        for (int k = 0; k < 12; k++) begin
            hit(32'h200);
            hit(32'h204);
        end
        drain("R4 warm-up then every third");

        // R3 count 0 as 1, R5 negative stride, R4 start 1
        fill(2, 32'h300, 32'h9000, 32'hffff_ffe0, 0, 1);
        for (int k = 0; k < 5; k++) hit(32'h300);
        drain("R5 negative stride");

        // R6: partially count, refill, counting restarts
        fill(1, 32'h200, 32'h7000, 32'h10, 3, 0);
        hit(32'h200); hit(32'h200);
        fill(1, 32'h200, 32'h6000, 32'h10, 3, 0);
        hit(32'h200);
        check(sb.size() == 0, "R6 refill clears counters", 32'(sb.size()), 32'd0);
        hit(32'h200); hit(32'h200);
        drain("R6 refill restart");

        // R7: two slots fire together, lower index first
        fill(3, 32'h100, 32'hA000, 32'h8, 1, 0);
        hit(32'h100); hit(32'h100);
        drain("R7 index order");

        // R8: hold memory not ready, overfill queue
        fill(3, 32'h500, 32'hB000, 32'h8, 1, 0);
        begin
            int d0 = int'(drop_count);
            @(negedge clk);
            mem_req_ready = 1'b0;
            blocked = 1'b1; held = 0; exp_drops = 0;
            for (int k = 0; k < 6; k++) hit(32'h100);
            repeat (4) @(negedge clk);
            check(int'(drop_count) == d0 + exp_drops, "R8 drop count",
                  32'(drop_count), 32'(d0 + exp_drops));
            check(exp_drops == 2, "R8 expected drops", 32'(exp_drops), 32'd2);
            check(mem_req_valid, "R9 valid held while not ready", 32'(mem_req_valid), 32'd1);
            blocked = 1'b0;
            mem_req_ready = 1'b1;
            drain("R8 queued survivors");
            check(int'(drop_count) == d0 + 2, "R8 drop count stable", 32'(drop_count), 32'(d0 + 2));
        end
        summary();
    end
endmodule